// File: doc/BRIEF.md
# SPI Flash Status Register Guard

This block is the command front end of a serial flash slave, restricted to the path that owns the 8-bit status register. A byte-level shim in front of it removes the serial clocking. It marks the opening of a chip-select frame with `frame_start` and the closing with `frame_end`, and delivers each received byte as a one-cycle `byte_valid` pulse. Within one frame, commands may be chained. A command that completes (write enable, status write, reset arm, reset) hands the next byte back to the opcode decoder. The status read keeps the frame until chip select rises.

The status register holds a write-enable latch in bit 1 and a write-disable control in bit 7. An active-low protect pin passes through two flops, and the synchronised level gates status writes together with bit 7. A write is refused only when the synchronised pin is low and bit 7 is set. In every other case, a write made while the latch is set is accepted. The latch clears after every status-write attempt.

The decoder state machine has five states:
- `ST_IDLE`: no frame is open.
- `ST_OPCODE`: the next byte is an opcode.
- `ST_WDATA`: the next byte is the new status value.
- `ST_READ`: the status is driven on every slot.
- `ST_SKIP`: an unknown opcode was seen, so the rest of the frame is dropped.

The transitions are as follows:
- Any state goes to `ST_IDLE` on `frame_end`, and to `ST_OPCODE` on `frame_start`.
- `ST_OPCODE` goes to `ST_WDATA` on 0x01, to `ST_READ` on 0x05, and to `ST_SKIP` on an unknown opcode. It stays in `ST_OPCODE` on 0x06, 0x66 and 0x99.
- `ST_WDATA` returns to `ST_OPCODE` after its data byte.

Top module: `spi_status_front`

## Requirements
- R1: After `rst_n` is released, the status reads 0x00 and `rd_valid` is low.
- R2: Opcode 0x06 sets status bit 1, the write-enable latch.
- R3: Opcode 0x01 followed by a data byte, with bit 1 set and no protection, loads the data into every bit except bit 1, which ends cleared.
- R4: A status write issued while bit 1 is clear leaves the status unchanged.
- R5: A write is blocked exactly when the synchronised `wp_n` is low and status bit 7 is set. A blocked write keeps every bit except bit 1, which clears.
- R6: After opcode 0x05, `rd_valid` is high and `rd_data` equals the status from the next cycle until `frame_end`. This includes writes made earlier in the same frame.
- R7: Opcode 0x66 followed by 0x99 as the very next opcode returns the status to 0x00. The two opcodes may be in the same frame or in successive frames.
- R8: An opcode 0x99 that is not directly preceded by 0x66 is ignored. Any other opcode after 0x66 cancels the arming.
- R9: After an unknown opcode, the rest of the frame is ignored.
- R10: `wp_n` acts through two flops, so a level change is not seen by a write in the first clock edge after it.
- R11: `frame_end` during a pending status write discards it, leaving the status and bit 1 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Asynchronous write-protect pin, active low |
| frame_start | input | 1 | One-cycle strobe: chip select fell |
| frame_end | input | 1 | One-cycle strobe: chip select rose |
| byte_valid | input | 1 | One-cycle strobe: `byte_in` holds a received byte |
| byte_in | input | 8 | Received byte |
| rd_valid | output | 1 | Status is being returned on the current slot |
| rd_data | output | 8 | Status byte to shift out (0 when `rd_valid` is low) |

## Verification
A corrupted write-enable latch or protect decision shows at the ports one cycle after the data byte, in the following ways:
- The next read in the same frame returns a status whose bit 1 or upper bits differ from the value the requirements predict.
- A wrong decoder state shows up in the byte slot after the opcode: `rd_valid` either fails to rise after 0x05, or rises after another opcode.
- A stale reset arm is revealed only by a later 0x99, which is why the bench reads the status after every arm-cancelling sequence.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_WREN  = 8'h06;
    localparam logic [BYTE_W-1:0] OP_WRSR  = 8'h01;
    localparam logic [BYTE_W-1:0] OP_RDSR  = 8'h05;
    localparam logic [BYTE_W-1:0] OP_ARM   = 8'h66;
    localparam logic [BYTE_W-1:0] OP_RESET = 8'h99;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_OPCODE = 3'd1,
        ST_WDATA  = 3'd2,
        ST_READ   = 3'd3,
        ST_SKIP   = 3'd4
    } dec_state_t;
endpackage

// File: rtl/ssf_wp_sync.sv
module ssf_wp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic level_n
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[i] <= 1'b1;
                end else if (i == 0) begin
                    chain[i] <= pin_n;
                end else begin
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign level_n = chain[STAGES-1];
endmodule

// File: rtl/ssf_decoder.sv
module ssf_decoder
    import ssf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              set_wel,
    output logic              wr_req,
    output logic [BYTE_W-1:0] wr_data,
    output logic              soft_rst,
    output logic              reading
);
    dec_state_t state, state_nx;
    logic       armed;
    logic       slot_ok;
    logic       op_slot;

    assign slot_ok = byte_valid && !frame_end && !frame_start;
    assign op_slot = slot_ok && (state == ST_OPCODE);

    // State register and reset-arm flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            armed <= 1'b0;
        end else begin
            state <= state_nx;
            if (op_slot) begin
                armed <= (byte_in == OP_ARM);
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (frame_end) begin
            state_nx = ST_IDLE;
        end else if (frame_start) begin
            state_nx = ST_OPCODE;
        end else if (byte_valid) begin
            unique case (state)
                ST_IDLE:   state_nx = ST_IDLE;
                ST_OPCODE: begin
                    if (byte_in == OP_WRSR) begin
                        state_nx = ST_WDATA;
                    end else if (byte_in == OP_RDSR) begin
                        state_nx = ST_READ;
                    end else if (byte_in == OP_WREN || byte_in == OP_ARM ||
                                 byte_in == OP_RESET) begin
                        state_nx = ST_OPCODE;
                    end else begin
                        state_nx = ST_SKIP;
                    end
                end
                ST_WDATA:  state_nx = ST_OPCODE;
                ST_READ:   state_nx = ST_READ;
                ST_SKIP:   state_nx = ST_SKIP;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // Output logic
    always_comb begin
        set_wel  = op_slot && (byte_in == OP_WREN);
        soft_rst = op_slot && (byte_in == OP_RESET) && armed;
        wr_req   = slot_ok && (state == ST_WDATA);
        wr_data  = byte_in;
        reading  = (state == ST_READ);
    end
endmodule

// File: rtl/ssf_status_reg.sv
module ssf_status_reg #(
    parameter int              WIDTH    = 8,
    parameter int              WEL_BIT  = 1,
    parameter int              LOCK_BIT = 7,
    parameter logic [WIDTH-1:0] DEFAULT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_wel,
    input  logic             wr_req,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             soft_rst,
    input  logic             wp_level_n,
    output logic [WIDTH-1:0] status
);
    localparam logic [WIDTH-1:0] WEL_MASK = WIDTH'(1) << WEL_BIT;

    logic locked;
    logic accept;

    assign locked = !wp_level_n && status[LOCK_BIT];
    assign accept = status[WEL_BIT] && !locked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= DEFAULT;
        end else if (soft_rst) begin
            status <= DEFAULT;
        end else if (wr_req) begin
            if (accept) begin
                status <= wr_data & ~WEL_MASK;
            end else begin
                status <= status & ~WEL_MASK;
            end
        end else if (set_wel) begin
            status <= status | WEL_MASK;
        end
    end
endmodule

// File: rtl/spi_status_front.sv
module spi_status_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wp_n,
    input  logic       frame_start,
    input  logic       frame_end,
    input  logic       byte_valid,
    input  logic [7:0] byte_in,
    output logic       rd_valid,
    output logic [7:0] rd_data
);
    import ssf_pkg::*;

    logic              wp_level_n;
    logic              set_wel;
    logic              wr_req;
    logic [BYTE_W-1:0] wr_data;
    logic              soft_rst;
    logic              reading;
    logic [BYTE_W-1:0] status;

    ssf_wp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (wp_n),
        .level_n (wp_level_n)
    );

    ssf_decoder u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .byte_valid  (byte_valid),
        .byte_in     (byte_in),
        .set_wel     (set_wel),
        .wr_req      (wr_req),
        .wr_data     (wr_data),
        .soft_rst    (soft_rst),
        .reading     (reading)
    );

    ssf_status_reg #(.WIDTH(BYTE_W), .WEL_BIT(1), .LOCK_BIT(7), .DEFAULT(8'h00)) u_sr (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_wel    (set_wel),
        .wr_req     (wr_req),
        .wr_data    (wr_data),
        .soft_rst   (soft_rst),
        .wp_level_n (wp_level_n),
        .status     (status)
    );

    always_comb begin
        rd_valid = reading;
        rd_data  = reading ? status : '0;
    end
endmodule

// File: rtl/spi_status_front_chk.sv
module spi_status_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_req,
    input logic [7:0] wr_data,
    input logic       soft_rst,
    input logic       set_wel,
    input logic       wp_level_n,
    input logic [7:0] status,
    input logic       frame_end,
    input logic       rd_valid
);
    // R4: no latch, no change
    a_r4_no_latch_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !status[1]) |=> (status == $past(status)));

    // R5: protected write keeps contents, latch cleared
    a_r5_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && status[1] && !wp_level_n && status[7])
        |=> (status == ($past(status) & 8'hFD)));

    // R3: accepted write loads the data with the latch cleared
    a_r3_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && status[1] && (wp_level_n || !status[7]))
        |=> (status == ($past(wr_data) & 8'hFD)));

    // R7: reset returns the default
    a_r7_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (status == 8'h00));

    // R2: write enable sets the latch
    a_r2_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_wel |=> status[1]);

    // R6: read ends with the frame
    a_r6_read_ends: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !rd_valid);
endmodule

bind spi_status_front spi_status_front_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_req     (wr_req),
    .wr_data    (wr_data),
    .soft_rst   (soft_rst),
    .set_wel    (set_wel),
    .wp_level_n (wp_level_n),
    .status     (status),
    .frame_end  (frame_end),
    .rd_valid   (rd_valid)
);

// File: tb/spi_status_front_bench.sv
`timescale 1ns/1ps
module spi_status_front_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wp_n = 1'b1;
    logic       frame_start = 1'b0;
    logic       frame_end = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       rd_valid;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    spi_status_front u_spi_status_front (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .frame_start(frame_start),
        .frame_end(frame_end), .byte_valid(byte_valid), .byte_in(byte_in),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // {wp_n, preset, new value, expected status}
    localparam logic [24:0] VEC [6] = '{
        {1'b1, 8'h00, 8'h80, 8'h80},
        {1'b1, 8'h80, 8'h00, 8'h00},
        {1'b0, 8'h00, 8'h80, 8'h80},
        {1'b0, 8'h80, 8'h00, 8'h80},
        {1'b0, 8'h84, 8'h3C, 8'h84},
        {1'b1, 8'h84, 8'h3E, 8'h3C}
    };

    task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic fstart();
        frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic fend();
        frame_end = 1'b1; @(negedge clk); frame_end = 1'b0; @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        byte_valid = 1'b1; byte_in = b; @(negedge clk); byte_valid = 1'b0;
    endtask

    task automatic set_status(input logic [7:0] v);
        fstart(); send(8'h06); send(8'h01); send(v); fend();
    endtask

    task automatic read_check(input string req, input logic [7:0] exp);
        fstart(); send(8'h05);
        check(req, {rd_valid, rd_data}, {1'b1, exp});
        fend();
    endtask

    task automatic set_wp(input logic v);
        wp_n = v; repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset rd_valid", {8'h00, rd_valid}, 9'h0);
        rst_n = 1'b1;
        @(negedge clk);
        read_check("R1 default status", 8'h00);

        // Vector table
        foreach (VEC[i]) begin
            set_wp(1'b1);
            set_status(VEC[i][23:16]);
            set_wp(VEC[i][24]);
            fstart(); send(8'h06); send(8'h01); send(VEC[i][15:8]); send(8'h05);
            check("R5/R3/R6 table", {rd_valid, rd_data}, {1'b1, VEC[i][7:0]});
            fend();
        end
        set_wp(1'b1);

        // R2: latch visible
        set_status(8'h00);
        fstart(); send(8'h06); send(8'h05);
        check("R2 wren latch", {rd_valid, rd_data}, {1'b1, 8'h02});
        send(8'hFF);
        check("R6 second slot", {rd_valid, rd_data}, {1'b1, 8'h02});
        fend();
        check("R6 ends at frame end", {8'h00, rd_valid}, 9'h0);

        // R4: write without latch (latch was left set: clear via write first)
        set_status(8'h00);
        fstart(); send(8'h01); send(8'h5C); send(8'h05);
        check("R4 no latch ignored", {rd_valid, rd_data}, {1'b1, 8'h00});
        fend();

        // R11: frame end drops pending write
        fstart(); send(8'h06); send(8'h01); fend();
        read_check("R11 pending write discarded", 8'h02);

        // R9: unknown opcode skips frame
        set_status(8'h00);
        fstart(); send(8'hAB); send(8'h06); send(8'h05);
        check("R9 skip rd_valid", {8'h00, rd_valid}, 9'h0);
        fend();
        read_check("R9 skip no latch", 8'h00);

        // R8: unarmed reset ignored, cancelled arm ignored
        set_status(8'h80);
        fstart(); send(8'h99); fend();
        read_check("R8 unarmed 0x99", 8'h80);
        fstart(); send(8'h66); send(8'h05); fend();
        fstart(); send(8'h99); fend();
        read_check("R8 cancelled arm", 8'h80);

        // R7: reset across frames and within a frame
        fstart(); send(8'h66); fend();
        fstart(); send(8'h99); fend();
        read_check("R7 reset across frames", 8'h00);
        set_status(8'h84);
        fstart(); send(8'h66); send(8'h99); send(8'h05);
        check("R7 reset same frame", {rd_valid, rd_data}, {1'b1, 8'h00});
        fend();

        // R10: wp change not seen by a write one edge later
        set_status(8'h80);
        fstart(); send(8'h06); send(8'h01);
        wp_n = 1'b0;
        send(8'h00);
        send(8'h05);
        check("R10 sync delay", {rd_valid, rd_data}, {1'b1, 8'h00});
        fend();
        set_wp(1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule